// File: doc/BRIEF.md
# Byte-Wide Serial Port with Banked Divisor Access

This block is a bus-attached asynchronous serial port with one transmit line, one receive line and one interrupt output. A host selects one of eight byte registers with a 3-bit offset, and the access counts only when both active-high chip selects are high and the active-low select is low. Characters are framed as one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity and only a single holding register in each direction.

Bit timing comes from a 16-bit divisor. A free-running counter produces one oversampling tick every `divisor` clocks, and every bit lasts sixteen ticks, so the baud rate is clk / (16 × divisor). For example, 4 MHz with divisor 26 gives about 9600 baud, and 1.8432 MHz with divisor 12 gives exactly 9600 baud. Bit 7 of the line control register is the bank bit. When it is set, offsets 0 and 1 reach the divisor bytes instead of the data and interrupt-enable registers. Offsets 0 and 2 decode to different registers on read and on write.

The transmitter state machine has the states TX_IDLE, TX_START, TX_DATA and TX_STOP:
- TX_IDLE → TX_START when the holding register is full; the byte is taken into the shifter.
- TX_START → TX_DATA after 16 ticks.
- TX_DATA → TX_STOP after the eighth bit's 16 ticks.
- TX_STOP → TX_IDLE after 16 ticks.

The receiver state machine has the states RX_IDLE, RX_START, RX_DATA, RX_STOP and RX_HOLD:
- RX_IDLE → RX_START on a tick that sees the line low.
- RX_START → RX_IDLE if the line is high at mid-bit (the 8th tick); otherwise RX_START → RX_DATA.
- RX_DATA → RX_STOP after the eighth centre sample.
- RX_STOP → RX_IDLE when the stop bit is sampled high.
- RX_STOP → RX_HOLD when the stop bit is sampled low.
- RX_HOLD → RX_IDLE once the line returns high.

Top module: `sio_port`

## Requirements
- R1: A write changes no register, and `rdata` reads 0x00, unless `sel_a`=1, `sel_b`=1 and `sel_n`=0.
- R2: After reset the register values are as follows: line control 0x00, interrupt enable 0x00, modem control 0x00, interrupt status 0x01, line status 0x60. `irq` is 0 and `txd` is 1.
- R3: With line control bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 the high byte. With that bit clear, offset 0 reads the received byte and writes the transmit byte, and offset 1 reaches interrupt enable (bits 3:0 stored, bits 7:4 read 0). Writing 0x03 to offset 3 clears the bank bit, and offset 3 reads back the value written.
- R4: Each data bit on `txd` lasts exactly 16 × divisor clocks. A divisor of 0 behaves as 1.
- R5: Writing offset 0 sends start (0), the 8 data bits LSB first, then stop (1). Line status bit 5 is 0 while the holding register waits for the shifter. Bit 6 is 1 only when both the holding register and the shifter are empty.
- R6: A received frame stores its byte and sets line status bit 0. Reading offset 0 clears bit 0.
- R7: A low pulse on `rxd` that is shorter than half a bit is discarded at the mid-bit check and receives nothing.
- R8: A frame that completes while line status bit 0 is still set sets bit 1 (overrun) and replaces the stored byte. Reading line status (offset 5) clears bits 1 and 3.
- R9: A stop bit sampled low sets line status bit 3. The byte is still stored, and reception resumes only after the line returns high.
- R10: Interrupt status (offset 2) reads 0x04 and `irq` is 1 when interrupt enable bit 0 and line status bit 0 are both set. Otherwise it reads 0x01 and `irq` is 0.
- R11: Offset 7 reads back any byte written. Modem control (offset 4) reads back bits 4:0. Offset 6 reads 0x00. Writes to offsets 2, 5 and 6 change nothing visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; clears read-sensitive status at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Received-data interrupt |

## Verification
The hardest conditions to reach from the ports are the receiver's abnormal endings. For an overrun, a frame must finish while the previous byte is still unread. For a framing error, the stop bit must be held low long enough that the RX_HOLD wait is exercised without the line looking like a new start. The bench drives `rxd` bit by bit at the programmed bit period. It sends two frames back to back with no read between them, and it sends one frame whose line stays low for two extra bit times. A short glitch that the mid-bit check must reject is also sent. Status is then read in a fixed order to show which clear is caused by which read.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_state_e;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_IEN   = 3'd1;
    localparam logic [2:0] OFS_ISTAT = 3'd2;
    localparam logic [2:0] OFS_LCTL  = 3'd3;
    localparam logic [2:0] OFS_MCTL  = 3'd4;
    localparam logic [2:0] OFS_LSTAT = 3'd5;
    localparam logic [2:0] OFS_MSTAT = 3'd6;
    localparam logic [2:0] OFS_SCR   = 3'd7;

    localparam int OVERSAMPLE = 16;
    localparam int DATA_BITS  = 8;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    always_comb limit = (divisor == '0) ? '0 : divisor - DIV_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (cnt >= limit)   cnt <= '0;
        else                     cnt <= cnt + DIV_W'(1);
    end

    assign tick = (cnt >= limit);

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit != '0) |=> (!tick || limit == '0));
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int NBITS = DATA_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [NBITS-1:0] data,
    output logic             take,
    output logic             busy,
    output logic             txd
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam int BW = $clog2(NBITS);
    localparam logic [CW-1:0] LAST_TICK = CW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(NBITS - 1);

    tx_state_e        st, nxt;
    logic [CW-1:0]    tcnt;
    logic [BW-1:0]    bidx;
    logic [NBITS-1:0] shreg;
    logic             bit_end;

    assign bit_end = tick && (tcnt == LAST_TICK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            TX_IDLE:  if (load)                          nxt = TX_START;
            TX_START: if (bit_end)                       nxt = TX_DATA;
            TX_DATA:  if (bit_end && bidx == LAST_BIT)   nxt = TX_STOP;
            TX_STOP:  if (bit_end)                       nxt = TX_IDLE;
            default:                                     nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
        end else if (take) begin
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= data;
        end else if (st != TX_IDLE && tick) begin
            tcnt <= tcnt + CW'(1);
            if (bit_end && st == TX_DATA) begin
                shreg <= shreg >> 1;
                bidx  <= bidx + BW'(1);
            end
        end
    end

    always_comb begin
        take = 1'b0;
        busy = 1'b1;
        txd  = 1'b1;
        unique case (st)
            TX_IDLE:  begin busy = 1'b0; take = load; end
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

    // R5
    tx_take_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (st == TX_START));
    // R5
    tx_stop_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_DATA && bit_end && bidx == LAST_BIT) |=> (st == TX_STOP && txd));
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int NBITS = DATA_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd,
    output logic             done,
    output logic             ferr,
    output logic [NBITS-1:0] data
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam int BW = $clog2(NBITS);
    localparam logic [CW-1:0] LAST_TICK = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] MID_TICK  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(NBITS - 1);

    rx_state_e        st, nxt;
    logic             rx_s1, rx_s2;
    logic [CW-1:0]    tcnt;
    logic [BW-1:0]    bidx;
    logic [NBITS-1:0] shreg;
    logic             bit_end, mid_pt;

    assign bit_end = tick && (tcnt == LAST_TICK);
    assign mid_pt  = tick && (tcnt == MID_TICK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_s1 <= 1'b1;
            rx_s2 <= 1'b1;
        end else begin
            rx_s1 <= rxd;
            rx_s2 <= rx_s1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            RX_IDLE:  if (tick && !rx_s2)                nxt = RX_START;
            RX_START: if (mid_pt)                        nxt = rx_s2 ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && bidx == LAST_BIT)   nxt = RX_STOP;
            RX_STOP:  if (bit_end)                       nxt = rx_s2 ? RX_IDLE : RX_HOLD;
            RX_HOLD:  if (rx_s2)                         nxt = RX_IDLE;
            default:                                     nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            done  <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                RX_IDLE: begin
                    tcnt <= '0;
                    bidx <= '0;
                end
                RX_START: begin
                    if (mid_pt)    tcnt <= '0;
                    else if (tick) tcnt <= tcnt + CW'(1);
                end
                RX_DATA: begin
                    if (tick) tcnt <= tcnt + CW'(1);
                    if (bit_end) begin
                        shreg <= {rx_s2, shreg[NBITS-1:1]};
                        bidx  <= bidx + BW'(1);
                    end
                end
                RX_STOP: begin
                    if (tick) tcnt <= tcnt + CW'(1);
                    if (bit_end) begin
                        done <= 1'b1;
                        ferr <= !rx_s2;
                    end
                end
                RX_HOLD: tcnt <= '0;
                default: tcnt <= '0;
            endcase
        end
    end

    assign data = shreg;

    // R7
    rx_glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_START && mid_pt && rx_s2) |=> (st == RX_IDLE && !done));
    // R9
    rx_hold_on_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_STOP && bit_end && !rx_s2) |=> (st == RX_HOLD));
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter logic [15:0] RESET_DIV = 16'd1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_a,
    input  logic       sel_b,
    input  logic       sel_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    localparam int DIV_W = 16;

    logic       cs, wr, rd, bank;
    logic [7:0] rbr, thr, lcr, scr, dll, dlm;
    logic [3:0] ier;
    logic [4:0] mcr;
    logic       dr, oe, fe, thr_full;
    logic       tick, take, tx_busy, rx_done, rx_ferr;
    logic [7:0] rx_byte, isr_v, lsr_v;
    logic       rd_rbr, rd_lsr, wr_thr;

    assign cs     = sel_a && sel_b && !sel_n;
    assign wr     = wr_en && cs;
    assign rd     = rd_en && cs;
    assign bank   = lcr[7];
    assign rd_rbr = rd && addr == OFS_DATA && !bank;
    assign rd_lsr = rd && addr == OFS_LSTAT;
    assign wr_thr = wr && addr == OFS_DATA && !bank;

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor({dlm, dll}), .tick(tick)
    );

    sio_tx #(.NBITS(DATA_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(thr_full), .data(thr),
        .take(take), .busy(tx_busy), .txd(txd)
    );

    sio_rx #(.NBITS(DATA_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .done(rx_done), .ferr(rx_ferr), .data(rx_byte)
    );

    // Control register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr <= '0;
            ier <= '0;
            mcr <= '0;
            scr <= '0;
            dll <= RESET_DIV[7:0];
            dlm <= RESET_DIV[15:8];
            thr <= '0;
        end else if (wr) begin
            unique case (addr)
                OFS_DATA:  if (bank) dll <= wdata; else thr <= wdata;
                OFS_IEN:   if (bank) dlm <= wdata; else ier <= wdata[3:0];
                OFS_LCTL:  lcr <= wdata;
                OFS_MCTL:  mcr <= wdata[4:0];
                OFS_SCR:   scr <= wdata;
                default:   ;
            endcase
        end
    end

    // Holding register occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thr_full <= 1'b0;
        else if (wr_thr) thr_full <= 1'b1;
        else if (take)   thr_full <= 1'b0;
    end

    // Receive status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbr <= '0;
            dr  <= 1'b0;
            oe  <= 1'b0;
            fe  <= 1'b0;
        end else begin
            if (rd_lsr) begin
                oe <= 1'b0;
                fe <= 1'b0;
            end
            if (rx_done) begin
                rbr <= rx_byte;
                dr  <= 1'b1;
                if (dr && !rd_rbr) oe <= 1'b1;
                if (rx_ferr)       fe <= 1'b1;
            end else if (rd_rbr) begin
                dr <= 1'b0;
            end
        end
    end

    always_comb begin
        isr_v = (ier[0] && dr) ? 8'h04 : 8'h01;
        lsr_v = {1'b0, !thr_full && !tx_busy, !thr_full, 1'b0, fe, 1'b0, oe, dr};
    end

    assign irq = ier[0] && dr;

    always_comb begin
        rdata = 8'h00;
        if (cs) begin
            unique case (addr)
                OFS_DATA:  rdata = bank ? dll : rbr;
                OFS_IEN:   rdata = bank ? dlm : {4'h0, ier};
                OFS_ISTAT: rdata = isr_v;
                OFS_LCTL:  rdata = lcr;
                OFS_MCTL:  rdata = {3'b000, mcr};
                OFS_LSTAT: rdata = lsr_v;
                OFS_MSTAT: rdata = 8'h00;
                OFS_SCR:   rdata = scr;
                default:   rdata = 8'h00;
            endcase
        end
    end

    // R1
    cs_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cs) |=> ($stable(scr) && $stable(lcr) && $stable(mcr)));
    // R3
    lctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_LCTL) |=> (lcr == $past(wdata)));
    // R6
    rbr_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rbr && !rx_done) |=> !dr);
    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(rx_done) || $past(wr && addr == OFS_IEN && !bank)));
endmodule

// File: tb/sim_sio_port.sv
module sim_sio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_a = 1'b0, sel_b = 1'b0, sel_n = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sio_port u0 (
        .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .sel_n(sel_n),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .rxd(rxd), .txd(txd), .irq(irq)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_wr_cs(input logic [2:0] a, input logic [7:0] d,
                             input logic sa, input logic sb, input logic sn);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; sel_a = sa; sel_b = sb; sel_n = sn;
        @(negedge clk);
        wr_en = 1'b0; sel_a = 1'b0; sel_b = 1'b0; sel_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr_cs(a, d, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic bus_rd_cs(input logic [2:0] a, output logic [7:0] d,
                             input logic sa, input logic sb, input logic sn);
        @(negedge clk);
        addr = a; rd_en = 1'b1; sel_a = sa; sel_b = sb; sel_n = sn;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; sel_a = 1'b0; sel_b = 1'b0; sel_n = 1'b1;
    endtask

    task automatic rd_chk(input logic [2:0] a, input int exp, input string req);
        logic [7:0] v;
        bus_rd_cs(a, v, 1'b1, 1'b1, 1'b0);
        check(req, v, exp);
    endtask

    task automatic set_div(input logic [7:0] lo, input logic [7:0] hi);
        bus_wr(3'd3, 8'h80);
        bus_wr(3'd0, lo);
        bus_wr(3'd1, hi);
        bus_wr(3'd3, 8'h03);
    endtask

    task automatic rx_send(input logic [7:0] b, input bit good_stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (16) @(negedge clk);
        end
        if (good_stop) begin
            rxd = 1'b1;
            repeat (16) @(negedge clk);
        end else begin
            rxd = 1'b0;
            repeat (48) @(negedge clk);
            rxd = 1'b1;
            repeat (16) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic tx_capture(output logic [7:0] b, output logic stopv);
        int guard = 0;
        b = '0;
        while (txd !== 1'b0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (8) @(negedge clk);
        check("R5 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (16) @(negedge clk);
            b[i] = txd;
        end
        repeat (16) @(negedge clk);
        stopv = txd;
    endtask

    task automatic t_reset();
        check("R2 irq", irq, 0);
        check("R2 txd", txd, 1);
        rd_chk(3'd3, 8'h00, "R2 lctl");
        rd_chk(3'd1, 8'h00, "R2 ien");
        rd_chk(3'd4, 8'h00, "R2 mctl");
        rd_chk(3'd2, 8'h01, "R2 istat");
        rd_chk(3'd5, 8'h60, "R2 lstat");
    endtask

    task automatic t_regs();
        bus_wr(3'd7, 8'hA5);
        rd_chk(3'd7, 8'hA5, "R11 scratch");
        bus_wr(3'd4, 8'hFF);
        rd_chk(3'd4, 8'h1F, "R11 mctl");
        bus_wr(3'd5, 8'h00);
        bus_wr(3'd6, 8'hFF);
        bus_wr(3'd2, 8'hC7);
        rd_chk(3'd5, 8'h60, "R11 lstat after ignored write");
        rd_chk(3'd6, 8'h00, "R11 mstat");
        rd_chk(3'd2, 8'h01, "R11 istat after offset 2 write");
        check("R11 txd idle", txd, 1);
    endtask

    task automatic t_select();
        logic [7:0] v;
        bus_wr_cs(3'd7, 8'h3C, 1'b0, 1'b1, 1'b0);
        bus_wr_cs(3'd7, 8'h3C, 1'b1, 1'b0, 1'b0);
        bus_wr_cs(3'd7, 8'h3C, 1'b1, 1'b1, 1'b1);
        bus_wr_cs(3'd3, 8'h80, 1'b1, 1'b1, 1'b1);
        rd_chk(3'd7, 8'hA5, "R1 scratch unchanged");
        rd_chk(3'd3, 8'h00, "R1 lctl unchanged");
        bus_rd_cs(3'd7, v, 1'b1, 1'b1, 1'b1);
        check("R1 rdata deselected", v, 8'h00);
        bus_rd_cs(3'd5, v, 1'b0, 1'b1, 1'b0);
        check("R1 rdata deselected", v, 8'h00);
    endtask

    task automatic t_bank();
        bus_wr(3'd3, 8'h83);
        bus_wr(3'd0, 8'h12);
        bus_wr(3'd1, 8'h34);
        rd_chk(3'd0, 8'h12, "R3 divisor low");
        rd_chk(3'd1, 8'h34, "R3 divisor high");
        rd_chk(3'd5, 8'h60, "R3 banked write not sent");
        check("R3 txd idle", txd, 1);
        bus_wr(3'd0, 8'h01);
        bus_wr(3'd1, 8'h00);
        bus_wr(3'd3, 8'h03);
        rd_chk(3'd3, 8'h03, "R3 lctl readback");
        bus_wr(3'd1, 8'hFA);
        rd_chk(3'd1, 8'h0A, "R3 ien readback");
        rd_chk(3'd0, 8'h00, "R3 data bank restored");
        bus_wr(3'd1, 8'h00);
    endtask

    task automatic t_tx();
        logic [7:0] b1, b2;
        logic s1, s2;
        fork
            begin
                tx_capture(b1, s1);
                tx_capture(b2, s2);
            end
            begin
                bus_wr(3'd0, 8'hA5);
                bus_wr(3'd0, 8'h3C);
                rd_chk(3'd5, 8'h00, "R5 holding full");
            end
        join
        check("R5 byte1", b1, 8'hA5);
        check("R5 stop1", s1, 1);
        check("R5 byte2", b2, 8'h3C);
        check("R5 stop2", s2, 1);
        repeat (20) @(negedge clk);
        rd_chk(3'd5, 8'h60, "R5 empty after send");
    endtask

    task automatic measure_bit(input int exp, input string req);
        int n = 0;
        int guard = 0;
        bus_wr(3'd0, 8'h55);
        while (txd !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        while (txd !== 1'b1 && guard < 8000) begin @(negedge clk); guard++; end
        do begin
            @(negedge clk);
            n++;
        end while (txd === 1'b1 && n < 4000);
        check(req, n, exp);
        repeat (12 * exp) @(negedge clk);
    endtask

    task automatic t_baud();
        set_div(8'd3, 8'd0);
        measure_bit(48, "R4 divisor 3");
        set_div(8'd0, 8'd0);
        measure_bit(16, "R4 divisor 0");
        set_div(8'd1, 8'd0);
        measure_bit(16, "R4 divisor 1");
    endtask

    task automatic t_rx();
        rx_send(8'hC3, 1'b1);
        rd_chk(3'd5, 8'h61, "R6 data ready");
        rd_chk(3'd0, 8'hC3, "R6 byte");
        rd_chk(3'd5, 8'h60, "R6 ready cleared");
    endtask

    task automatic t_glitch();
        @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        rd_chk(3'd5, 8'h60, "R7 glitch ignored");
    endtask

    task automatic t_overrun();
        rx_send(8'h11, 1'b1);
        rx_send(8'h22, 1'b1);
        rd_chk(3'd5, 8'h63, "R8 overrun set");
        rd_chk(3'd5, 8'h61, "R8 overrun cleared by status read");
        rd_chk(3'd0, 8'h22, "R8 newer byte kept");
    endtask

    task automatic t_ferr();
        rx_send(8'h5A, 1'b0);
        rd_chk(3'd5, 8'h69, "R9 framing error");
        rd_chk(3'd0, 8'h5A, "R9 byte stored");
        rd_chk(3'd5, 8'h60, "R9 cleared");
        rx_send(8'h96, 1'b1);
        rd_chk(3'd0, 8'h96, "R9 resumes");
    endtask

    task automatic t_irq();
        bus_wr(3'd1, 8'h01);
        rd_chk(3'd2, 8'h01, "R10 nothing pending");
        check("R10 irq low", irq, 0);
        rx_send(8'h7E, 1'b1);
        check("R10 irq high", irq, 1);
        rd_chk(3'd2, 8'h04, "R10 data pending");
        bus_wr(3'd1, 8'h00);
        check("R10 irq masked", irq, 0);
        rd_chk(3'd2, 8'h01, "R10 masked status");
        bus_wr(3'd1, 8'h01);
        check("R10 irq unmasked", irq, 1);
        rd_chk(3'd0, 8'h7E, "R10 byte");
        check("R10 irq after read", irq, 0);
        rd_chk(3'd2, 8'h01, "R10 status after read");
        bus_wr(3'd1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regs();
        t_select();
        t_bank();
        t_tx();
        t_baud();
        t_rx();
        t_glitch();
        t_overrun();
        t_ferr();
        t_irq();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule